// File: doc/BRIEF.md
# Dual-Compare Capture/Match Timer Channel Group

This block is a group of timer channels driven by one shared prescaler. Every channel owns a free-running up-counter and two comparison registers, A and B. The channel runs against one of three timebases: its own counter, the counter of the first channel in its group, or the counter of one designated channel that the whole array can see. Both shared counters travel on plain wires to their consumers.

A channel works in one of four modes. It can be off. It can run as a counter that reloads itself from register B. It can drive a pulse on its pin, where a match on A raises the pin and a match on B lowers it. It can also capture the selected timebase into register A when its synchronised input pin shows the chosen edge. Matches set per-channel event flags. Each flag has a shadow copy that software clears on its own. A per-channel interrupt merges the enabled flags, and a freeze input stops the timing state so a debugger can inspect it.

Software sets up channels through a one-cycle write strobe that carries a channel number and a two-bit address. A combinational read port returns the registers and the counter of any channel.

Top module: `ucc_timer_group`

## Requirements
- R1: After a synchronous reset, every counter, A, B and control register, flag, shadow flag, pin output and the prescaler are zero.
- R2: In any mode other than off, the channel's own counter advances on each prescaler tick. If it equals B at that tick, it loads 1. Otherwise it adds 1 and wraps modulo 2^CW. In the off mode the counter holds.
- R3: The prescaler ticks once every presc_div_i+1 clock cycles, and the same tick paces every channel.
- R4: Control bits [3:2] pick the timebase. 0 or 3 picks the channel's own counter. 1 picks the counter of the first channel of its GROUP-sized group. 2 picks the counter of channel BUS_A_CH.
- R5: Control bits [1:0] pick the mode: 0 off, 1 counter, 2 pulse output, 3 capture. In pulse-output mode, a tick on which the timebase equals A drives the pin to 1 on the next cycle, and a tick on which it equals B drives it to 0. B wins when both match. In every other mode the pin is 0.
- R6: In capture mode, the input pin passes through two synchroniser flops and an edge-detect flop, so a pin change seen at clock edge k is acted on at edge k+2. Control bits [5:4] pick the edge: 0 none, 1 rising, 2 falling, 3 both. A detected edge copies the timebase into A and sets flag A, and it wins over a write to A in the same cycle.
- R7: In counter and pulse modes, an A match sets flag A and a B match sets flag B. Writing address 3 clears flag A when data bit 0 is 1 and flag B when data bit 1 is 1. A set in the same cycle wins over the clear.
- R8: irq_o for a channel is (flag A and control bit 6) or (flag B and control bit 7).
- R9: Each shadow flag is set by the same events as its flag. Shadow A is cleared only by data bit 2 of an address-3 write, and shadow B only by data bit 3.
- R10: While freeze_i is high, the prescaler, counters, pins, synchronisers, captures and match events hold. Register writes and flag clears are still accepted.
- R11: Write addresses are 0 for A, 1 for B, 2 for control (low 8 bits) and 3 for flag clear. Read addresses return 0 A, 1 B, 2 own counter, 3 control zero-extended. The read is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Debug halt of the timing state |
| presc_div_i | input | PW | Prescaler divide value minus one |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | CHW | Channel addressed by the write |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | CW | Write data |
| rd_ch_i | input | CHW | Channel addressed by the read |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | CW | Read data |
| pin_i | input | NUM_CH | Channel input pins (asynchronous) |
| pin_o | output | NUM_CH | Channel output pins |
| flag_a_o | output | NUM_CH | Event flag A per channel |
| flag_b_o | output | NUM_CH | Event flag B per channel |
| shadow_a_o | output | NUM_CH | Shadow of flag A |
| shadow_b_o | output | NUM_CH | Shadow of flag B |
| irq_o | output | NUM_CH | Per-channel interrupt request |

## Verification
The bench builds the group with sixteen channels in two groups of eight and channel 15 as the global bus driver, so bus isolation between groups can be seen at the pins. The counter is 8 bits wide, so the counter wraps and reloads within a few hundred cycles. The prescaler is 4 bits wide, so both a divide of 1 and a divide of 4 can be shown. A behavioural model advances in step with the design and compares pins, flags, shadows, interrupts and a rotating register read on every clock.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

    localparam int CTRL_W = 8;

    typedef enum logic [1:0] {M_OFF, M_COUNT, M_PWM, M_CAPT} mode_e;
    typedef enum logic [1:0] {TB_OWN, TB_LOCAL, TB_GLOBAL, TB_OWN_ALT} tb_e;
    typedef enum logic [1:0] {E_NONE, E_RISE, E_FALL, E_BOTH} edge_e;
    typedef enum logic [1:0] {AD_A, AD_B, AD_CTL_CNT, AD_CLR_CTL} addr_e;

    typedef struct packed {
        logic  ie_b;
        logic  ie_a;
        edge_e edg;
        tb_e   tb;
        mode_e mode;
    } ctrl_t;

    function automatic logic edge_match(edge_e sel, logic cur, logic prev);
        logic rise, fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (sel)
            E_RISE:  return rise;
            E_FALL:  return fall;
            E_BOTH:  return rise | fall;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ucc_prescaler.sv
module ucc_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frz,
    input  logic [PW-1:0] div,
    output logic          tick
);
    logic [PW-1:0] pc_q;

    assign tick = !frz && (pc_q >= div);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (!frz) begin
            pc_q <= (pc_q >= div) ? '0 : pc_q + PW'(1);
        end
    end
endmodule

// File: rtl/ucc_edge_sync.sv
module ucc_edge_sync
    import ucc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  pin_i,
    input  edge_e sel,
    output logic  hit
);
    logic s1_q, s2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q   <= 1'b0;
            s2_q   <= 1'b0;
            prev_q <= 1'b0;
        end else if (!hold) begin
            s1_q   <= pin_i;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    assign hit = edge_match(sel, s2_q, prev_q);
endmodule

// File: rtl/ucc_channel.sv
module ucc_channel
    import ucc_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frz,
    input  logic          tick,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic          wr_ctrl,
    input  logic          wr_clr,
    input  logic [CW-1:0] wdata,
    input  logic [CW-1:0] bus_glb,
    input  logic [CW-1:0] bus_loc,
    input  logic          pin_i,
    output logic          pin_o,
    output logic          flag_a,
    output logic          flag_b,
    output logic          shad_a,
    output logic          shad_b,
    output logic          irq,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] rega_o,
    output logic [CW-1:0] regb_o,
    output ctrl_t         ctrl_o
);
    ctrl_t         ctrl_q;
    logic [CW-1:0] cnt_q, ra_q, rb_q, tbv;
    logic          act, cmp_en, hit_a, hit_b, edge_w, cap, set_a;

    ucc_edge_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .hold  (frz),
        .pin_i (pin_i),
        .sel   (ctrl_q.edg),
        .hit   (edge_w)
    );

    always_comb begin
        case (ctrl_q.tb)
            TB_LOCAL:  tbv = bus_loc;
            TB_GLOBAL: tbv = bus_glb;
            default:   tbv = cnt_q;
        endcase
    end

    assign act    = tick && (ctrl_q.mode != M_OFF);
    assign cmp_en = act && (ctrl_q.mode == M_COUNT || ctrl_q.mode == M_PWM);
    assign hit_a  = cmp_en && (tbv == ra_q);
    assign hit_b  = cmp_en && (tbv == rb_q);
    assign cap    = !frz && (ctrl_q.mode == M_CAPT) && edge_w;
    assign set_a  = hit_a || cap;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            ra_q   <= '0;
            rb_q   <= '0;
            flag_a <= 1'b0;
            flag_b <= 1'b0;
            shad_a <= 1'b0;
            shad_b <= 1'b0;
            pin_o  <= 1'b0;
        end else begin
            if (act)
                cnt_q <= (cnt_q == rb_q) ? CW'(1) : cnt_q + CW'(1);
            if (cap)
                ra_q <= tbv;
            else if (wr_a)
                ra_q <= wdata;
            if (wr_b)
                rb_q <= wdata;
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            flag_a <= set_a || (flag_a && !(wr_clr && wdata[0]));
            flag_b <= hit_b || (flag_b && !(wr_clr && wdata[1]));
            shad_a <= set_a || (shad_a && !(wr_clr && wdata[2]));
            shad_b <= hit_b || (shad_b && !(wr_clr && wdata[3]));
            if (!frz) begin
                if (ctrl_q.mode != M_PWM) pin_o <= 1'b0;
                else if (hit_b)           pin_o <= 1'b0;
                else if (hit_a)           pin_o <= 1'b1;
            end
        end
    end

    assign irq    = (flag_a && ctrl_q.ie_a) || (flag_b && ctrl_q.ie_b);
    assign cnt_o  = cnt_q;
    assign rega_o = ra_q;
    assign regb_o = rb_q;
    assign ctrl_o = ctrl_q;
endmodule

// File: rtl/ucc_timer_group.sv
module ucc_timer_group
    import ucc_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int GROUP    = 8,
    parameter int CW       = 24,
    parameter int PW       = 8,
    parameter int BUS_A_CH = NUM_CH - 1,
    localparam int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              freeze_i,
    input  logic [PW-1:0]     presc_div_i,
    input  logic              wr_en_i,
    input  logic [CHW-1:0]    wr_ch_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [CW-1:0]     wr_data_i,
    input  logic [CHW-1:0]    rd_ch_i,
    input  logic [1:0]        rd_addr_i,
    output logic [CW-1:0]     rd_data_o,
    input  logic [NUM_CH-1:0] pin_i,
    output logic [NUM_CH-1:0] pin_o,
    output logic [NUM_CH-1:0] flag_a_o,
    output logic [NUM_CH-1:0] flag_b_o,
    output logic [NUM_CH-1:0] shadow_a_o,
    output logic [NUM_CH-1:0] shadow_b_o,
    output logic [NUM_CH-1:0] irq_o
);
    logic                 tick_w;
    logic [CW-1:0]        cnt_w [NUM_CH];
    logic [CW-1:0]        ra_w  [NUM_CH];
    logic [CW-1:0]        rb_w  [NUM_CH];
    ctrl_t                ctrl_w[NUM_CH];
    logic [NUM_CH*CW-1:0] cnt_flat_w;
    logic [NUM_CH-1:0]    pwm_en_w;
    addr_e                waddr;

    assign waddr = addr_e'(wr_addr_i);

    ucc_prescaler #(.PW(PW)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .frz  (freeze_i),
        .div  (presc_div_i),
        .tick (tick_w)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam int LEAD = (i / GROUP) * GROUP;
        logic sel;
        assign sel = wr_en_i && (wr_ch_i == CHW'(i));

        ucc_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .frz     (freeze_i),
            .tick    (tick_w),
            .wr_a    (sel && waddr == AD_A),
            .wr_b    (sel && waddr == AD_B),
            .wr_ctrl (sel && waddr == AD_CTL_CNT),
            .wr_clr  (sel && waddr == AD_CLR_CTL),
            .wdata   (wr_data_i),
            .bus_glb (cnt_w[BUS_A_CH]),
            .bus_loc (cnt_w[LEAD]),
            .pin_i   (pin_i[i]),
            .pin_o   (pin_o[i]),
            .flag_a  (flag_a_o[i]),
            .flag_b  (flag_b_o[i]),
            .shad_a  (shadow_a_o[i]),
            .shad_b  (shadow_b_o[i]),
            .irq     (irq_o[i]),
            .cnt_o   (cnt_w[i]),
            .rega_o  (ra_w[i]),
            .regb_o  (rb_w[i]),
            .ctrl_o  (ctrl_w[i])
        );

        assign cnt_flat_w[i*CW +: CW] = cnt_w[i];
        assign pwm_en_w[i] = (ctrl_w[i].mode == M_PWM);
    end

    always_comb begin
        rd_data_o = '0;
        case (addr_e'(rd_addr_i))
            AD_A:       rd_data_o = ra_w[rd_ch_i];
            AD_B:       rd_data_o = rb_w[rd_ch_i];
            AD_CTL_CNT: rd_data_o = cnt_w[rd_ch_i];
            default:    rd_data_o[CTRL_W-1:0] = ctrl_w[rd_ch_i];
        endcase
    end
endmodule

// File: rtl/ucc_timer_group_chk.sv
module ucc_timer_group_chk #(
    parameter int NUM_CH = 16,
    parameter int CW     = 24,
    parameter int PW     = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              freeze_i,
    input logic              tick_i,
    input logic [PW-1:0]     presc_div_i,
    input logic [NUM_CH*CW-1:0] cnt_flat,
    input logic [NUM_CH-1:0] pwm_en,
    input logic [NUM_CH-1:0] pin_o,
    input logic [NUM_CH-1:0] flag_a_o,
    input logic [NUM_CH-1:0] flag_b_o,
    input logic [NUM_CH-1:0] shadow_a_o,
    input logic [NUM_CH-1:0] irq_o
);
    assert_presc_gap_R3: assert property (@(posedge clk) disable iff (rst)
        tick_i |=> (!tick_i || presc_div_i == '0));

    assert_freeze_cnt_R10: assert property (@(posedge clk) disable iff (rst)
        freeze_i |=> $stable(cnt_flat));

    assert_freeze_pin_R10: assert property (@(posedge clk) disable iff (rst)
        freeze_i |=> $stable(pin_o));

    assert_pin_low_R5: assert property (@(posedge clk) disable iff (rst)
        !freeze_i |=> ((pin_o & ~$past(pwm_en)) == '0));

    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~(flag_a_o | flag_b_o)) == '0);

    assert_shadow_follow_R9: assert property (@(posedge clk) disable iff (rst)
        (flag_a_o & ~$past(flag_a_o) & ~shadow_a_o) == '0);
endmodule

bind ucc_timer_group ucc_timer_group_chk #(
    .NUM_CH (NUM_CH),
    .CW     (CW),
    .PW     (PW)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .freeze_i    (freeze_i),
    .tick_i      (tick_w),
    .presc_div_i (presc_div_i),
    .cnt_flat    (cnt_flat_w),
    .pwm_en      (pwm_en_w),
    .pin_o       (pin_o),
    .flag_a_o    (flag_a_o),
    .flag_b_o    (flag_b_o),
    .shadow_a_o  (shadow_a_o),
    .irq_o       (irq_o)
);

// File: tb/tb_ucc_timer_group.sv
module tb_ucc_timer_group;
    localparam int N    = 16;
    localparam int GRP  = 8;
    localparam int CW   = 8;
    localparam int PW   = 4;
    localparam int BUSA = 15;
    localparam int CMOD = 1 << CW;

    logic          clk = 0;
    logic          rst = 1;
    logic          frz = 0;
    logic [PW-1:0] div = 0;
    logic          wr_en = 0;
    logic [3:0]    wr_ch = 0;
    logic [1:0]    wr_addr = 0;
    logic [CW-1:0] wr_data = 0;
    logic [3:0]    rd_ch = 0;
    logic [1:0]    rd_addr = 0;
    logic [CW-1:0] rd_data;
    logic [N-1:0]  pin_in = 0;
    logic [N-1:0]  pin_o, fa_o, fb_o, sa_o, sb_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit auto_rd = 1;
    int rd_idx = 0;

    ucc_timer_group #(.NUM_CH(N), .GROUP(GRP), .CW(CW), .PW(PW), .BUS_A_CH(BUSA)) dut (
        .clk(clk), .rst(rst), .freeze_i(frz), .presc_div_i(div),
        .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_ch_i(rd_ch), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pin_i(pin_in), .pin_o(pin_o), .flag_a_o(fa_o), .flag_b_o(fb_o),
        .shadow_a_o(sa_o), .shadow_b_o(sb_o), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    // behavioural reference state
    int m_cnt[N], m_ra[N], m_rb[N], m_ctl[N], m_pc;
    bit m_fa[N], m_fb[N], m_sa[N], m_sb[N], m_pin[N], m_s1[N], m_s2[N], m_pv[N];
    int n_cnt[N], n_ra[N], n_rb[N], n_ctl[N];
    bit n_fa[N], n_fb[N], n_sa[N], n_sb[N], n_pin[N], n_s1[N], n_s2[N], n_pv[N];

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(int ch, int a);
        case (a)
            0: return m_ra[ch];
            1: return m_rb[ch];
            2: return m_cnt[ch];
            default: return m_ctl[ch];
        endcase
    endfunction

    task automatic model_step();
        bit tick;
        tick = !frz && (m_pc >= int'(div));
        for (int c = 0; c < N; c++) begin
            int mode, tbs, edg, tbv;
            bit act, cmp, ha, hb, rise, fall, eok, cap, sel;
            mode = m_ctl[c] & 3;
            tbs  = (m_ctl[c] >> 2) & 3;
            edg  = (m_ctl[c] >> 4) & 3;
            if (tbs == 1)      tbv = m_cnt[(c / GRP) * GRP];
            else if (tbs == 2) tbv = m_cnt[BUSA];
            else               tbv = m_cnt[c];
            act  = tick && mode != 0;
            cmp  = act && (mode == 1 || mode == 2);
            ha   = cmp && tbv == m_ra[c];
            hb   = cmp && tbv == m_rb[c];
            rise = m_s2[c] && !m_pv[c];
            fall = !m_s2[c] && m_pv[c];
            eok  = (edg == 1 && rise) || (edg == 2 && fall) || (edg == 3 && (rise || fall));
            cap  = !frz && mode == 3 && eok;
            sel  = wr_en && int'(wr_ch) == c;
            n_cnt[c] = act ? ((m_cnt[c] == m_rb[c]) ? 1 : (m_cnt[c] + 1) % CMOD) : m_cnt[c];
            n_ra[c]  = cap ? tbv : ((sel && wr_addr == 0) ? int'(wr_data) : m_ra[c]);
            n_rb[c]  = (sel && wr_addr == 1) ? int'(wr_data) : m_rb[c];
            n_ctl[c] = (sel && wr_addr == 2) ? int'(wr_data) : m_ctl[c];
            n_fa[c]  = ha || cap || (m_fa[c] && !(sel && wr_addr == 3 && wr_data[0]));
            n_fb[c]  = hb || (m_fb[c] && !(sel && wr_addr == 3 && wr_data[1]));
            n_sa[c]  = ha || cap || (m_sa[c] && !(sel && wr_addr == 3 && wr_data[2]));
            n_sb[c]  = hb || (m_sb[c] && !(sel && wr_addr == 3 && wr_data[3]));
            n_pin[c] = m_pin[c];
            n_s1[c] = m_s1[c]; n_s2[c] = m_s2[c]; n_pv[c] = m_pv[c];
            if (!frz) begin
                if (mode != 2) n_pin[c] = 0;
                else if (hb)   n_pin[c] = 0;
                else if (ha)   n_pin[c] = 1;
                n_s1[c] = pin_in[c]; n_s2[c] = m_s1[c]; n_pv[c] = m_s2[c];
            end
        end
        if (!frz) m_pc = (m_pc >= int'(div)) ? 0 : m_pc + 1;
        for (int c = 0; c < N; c++) begin
            m_cnt[c] = n_cnt[c]; m_ra[c] = n_ra[c]; m_rb[c] = n_rb[c]; m_ctl[c] = n_ctl[c];
            m_fa[c] = n_fa[c]; m_fb[c] = n_fb[c]; m_sa[c] = n_sa[c]; m_sb[c] = n_sb[c];
            m_pin[c] = n_pin[c]; m_s1[c] = n_s1[c]; m_s2[c] = n_s2[c]; m_pv[c] = n_pv[c];
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_pc = 0;
            for (int c = 0; c < N; c++) begin
                m_cnt[c] = 0; m_ra[c] = 0; m_rb[c] = 0; m_ctl[c] = 0;
                m_fa[c] = 0; m_fb[c] = 0; m_sa[c] = 0; m_sb[c] = 0;
                m_pin[c] = 0; m_s1[c] = 0; m_s2[c] = 0; m_pv[c] = 0;
            end
        end else begin
            model_step();
        end
        #5;
        if (!rst) begin
            for (int c = 0; c < N; c++) begin
                bit eirq;
                eirq = (m_fa[c] && m_ctl[c][6]) || (m_fb[c] && m_ctl[c][7]);
                check("R5 pin", pin_o[c], m_pin[c]);
                check("R7 flag_a", fa_o[c], m_fa[c]);
                check("R7 flag_b", fb_o[c], m_fb[c]);
                check("R9 shadow_a", sa_o[c], m_sa[c]);
                check("R9 shadow_b", sb_o[c], m_sb[c]);
                check("R8 irq", irq_o[c], eirq);
            end
            case (rd_addr)
                2'd0: check("R6 read A", rd_data, model_read(rd_ch, 0));
                2'd2: check("R2 read counter", rd_data, model_read(rd_ch, 2));
                default: check("R11 read", rd_data, model_read(rd_ch, rd_addr));
            endcase
        end
    end

    always @(negedge clk) begin
        if (auto_rd) begin
            rd_idx++;
            rd_ch   = 4'((rd_idx / 4) % N);
            rd_addr = 2'(rd_idx % 4);
        end
    end

    task automatic wr(input int ch, input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_ch = 4'(ch); wr_addr = 2'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic peek(input int ch, input int a, output int v);
        @(negedge clk);
        auto_rd = 0; rd_ch = 4'(ch); rd_addr = 2'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int v0, v1, p0;
        idle(4);
        rst = 0;
        // R1: reset state
        for (int c = 0; c < N; c += 5) begin
            for (int a = 0; a < 4; a++) begin
                peek(c, a, v0);
                check("R1 reset register", v0, 0);
            end
        end
        check("R1 reset pins", int'(pin_o), 0);
        check("R1 reset flags", int'(fa_o | fb_o | sa_o | sb_o), 0);
        auto_rd = 1;

        // counter, pulse, bus setup (R2, R4, R5)
        wr(0, 1, 9);  wr(0, 0, 4);  wr(0, 2, 8'h41);
        wr(1, 0, 2);  wr(1, 1, 7);  wr(1, 2, 8'h86);
        wr(15, 1, 255); wr(15, 0, 100); wr(15, 2, 8'h01);
        wr(14, 1, 0); wr(14, 0, 128); wr(14, 2, 8'hC1);
        wr(9, 0, 5);  wr(9, 1, 200); wr(9, 2, 8'h0A);
        wr(10, 0, 0); wr(10, 1, 3);  wr(10, 2, 8'h06);
        idle(600);
        // R4: group 1 local bus driven by idle ch8, so B=3 is never reached
        check("R4 local bus isolation pin", pin_o[10], 1);
        check("R4 local bus isolation flag_b", fb_o[10], 0);
        check("R4 group0 local bus flag_a", fa_o[1], 1);

        // R3: divide by 4 gives four ticks in sixteen cycles
        div = 3;
        wr(5, 1, 255); wr(5, 2, 8'h01);
        peek(5, 2, v0);
        idle(15);
        peek(5, 2, v1);
        check("R3 prescaler rate", v1 - v0, 4);
        auto_rd = 1;
        div = 0;

        // R6: capture on several timebases and edges
        wr(2, 2, 8'h57); wr(3, 2, 8'h3B); wr(4, 2, 8'h23);
        for (int k = 0; k < 6; k++) begin
            idle(7 + 3 * k);
            pin_in[2] = ~pin_in[2];
            pin_in[3] = ~pin_in[3];
            idle(5);
            pin_in[4] = ~pin_in[4];
        end
        idle(10);

        // R7, R9: clears
        wr(0, 3, 8'h01);
        wr(1, 3, 8'h0C);
        wr(9, 3, 8'h0F);
        idle(30);

        // R10: freeze holds counters and pins, writes still land
        peek(15, 2, v0);
        frz = 1;
        p0 = int'(pin_o);
        pin_in[2] = ~pin_in[2];
        idle(10);
        peek(15, 2, v1);
        check("R10 counter held in freeze", v1, v0);
        check("R10 pins held in freeze", int'(pin_o), p0);
        wr(6, 1, 77);
        peek(6, 1, v1);
        check("R10 write accepted in freeze", v1, 77);
        frz = 0;
        auto_rd = 1;
        idle(60);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule